// File: doc/BRIEF.md
# Xon/Xoff In-Band Flow Controller

This block handles software flow control for one UART channel. It looks at every character the receiver hands to the receive FIFO and compares it with two programmable character registers. One register holds the "resume" character and the other holds the "pause" character. From these matches it does three things. It raises a one-cycle recognition interrupt. It can tell the FIFO to drop the character. It can also stop and restart the local transmitter.

In the other direction, the block asks the transmitter to insert a pause or resume character whenever the receive FIFO crosses a high or low fill mark. The host can also request a pause or resume character by command. A 2-bit mode field chooses one of four settings:

- The host controls everything.
- Received characters gate the transmitter.
- The fill level drives the inserted characters.
- Both automatic behaviours are active at once.

The transmitter offers an inserted character through a request/acknowledge pair. The character counts as sent in the cycle the transmitter takes it. A request that has not yet been taken is withdrawn as soon as its cause goes away.

Top module: `xonxoff_flow_ctrl`

## Requirements
- R1: After reset, `tx_en` is 1 and `ins_req`, `recog_irq`, `recog_status` and `xoff_outstanding` are 0. The resume character is 0x11 and the pause character is 0x13.
- R2: A received character (`rx_valid`=1, `rx_full`=0) that equals the pause register, or otherwise the resume register, is recognised in every mode. The cycle after recognition, `recog_irq` pulses for one cycle and `recog_status` reads 2'b10 for pause or 2'b01 for resume. `recog_status` holds until the next recognition. A write with `chr_wr`=1 sets the resume register when `chr_sel`=0 and the pause register when `chr_sel`=1. A new value takes effect on the following cycle.
- R3: A character that arrives with `rx_full`=1 is never recognised. It raises no interrupt, does not suppress the FIFO write and does not change `tx_en`.
- R4: In every mode, `rx_wr_suppress` is 1 in the same cycle as a recognised character when `strip`=1. It is 0 otherwise.
- R5: With `mode[0]`=1, a recognised pause character clears `tx_en` on the next cycle and a recognised resume character sets it. The host stop and resume commands have no effect in this setting.
- R6: With `mode[0]`=0, command 1 (stop) clears `tx_en` and command 2 (resume) sets it. Received characters do not change `tx_en` in this setting.
- R7: With `mode[1]`=1, the cycle after `rx_fill` > 240 while no pause is outstanding, `ins_req` rises with the pause character on `ins_char`. The cycle after `rx_fill` < 16 while a pause is outstanding, `ins_req` rises with the resume character.
- R8: If the fill condition behind an automatic request ends before `ins_ack`, the request drops on the next cycle and no character is sent.
- R9: `ins_ack`=1 while `ins_req`=1 consumes the offered character. Sending a pause sets `xoff_outstanding` and sending a resume clears it, so the same automatic character is never requested twice in a row. Automatic requests take priority over host requests.
- R10: While `mode`=00, `xoff_outstanding` is cleared and no automatic request is made, so leaving fill-driven mode with a pause outstanding produces no closing resume.
- R11: Command 3 requests a resume character and command 4 requests a pause character, in any mode. With `mode`=00, command 5 (kill) cancels a pending host request. In any other mode, kill leaves the request in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode | input | 2 | bit0 gates the transmitter from received characters; bit1 enables fill-driven insertion |
| strip | input | 1 | Drop recognised characters from the receive FIFO |
| chr_wr | input | 1 | Character register write strobe |
| chr_sel | input | 1 | Selects the register to write: 0 resume, 1 pause |
| chr_data | input | 8 | Character register write data |
| rx_valid | input | 1 | Receiver is writing a character |
| rx_data | input | 8 | Received character |
| rx_full | input | 1 | Receive FIFO is full, so the character overruns |
| rx_fill | input | 9 | Receive FIFO fill count |
| cmd_valid | input | 1 | Host command strobe |
| cmd_code | input | 3 | Command: 1 stop, 2 resume, 3 send resume, 4 send pause, 5 kill |
| ins_ack | input | 1 | Transmitter has loaded the offered character |
| tx_en | output | 1 | Transmitter may start new characters |
| ins_req | output | 1 | A flow character is offered |
| ins_char | output | 8 | Offered flow character |
| rx_wr_suppress | output | 1 | Do not store the current received character |
| recog_irq | output | 1 | One-cycle recognition pulse |
| recog_status | output | 2 | Last recognised kind: bit1 pause, bit0 resume |
| xoff_outstanding | output | 1 | A pause was sent and no resume has followed it |

## Verification
Two events can fall in the same cycle: the transmitter acknowledging an automatic pause request, and the fill level falling back below the high mark. The bench provokes this by driving `ins_ack` together with a lower `rx_fill`. It also does this repeatedly in a random walk of fill values clustered around both marks, with acknowledge pulses at random times. The acknowledged character counts as sent, because the request was visible when it was taken. So the bench expects `xoff_outstanding` to be set and no repeated pause. A withdrawal one cycle earlier must instead leave no trace.

// File: rtl/xf_pkg.sv
package xf_pkg;
    typedef enum logic [2:0] {
        CMD_NOP       = 3'd0,
        CMD_STOP      = 3'd1,
        CMD_RESUME    = 3'd2,
        CMD_SEND_XON  = 3'd3,
        CMD_SEND_XOFF = 3'd4,
        CMD_KILL      = 3'd5
    } xf_cmd_e;

    localparam logic [1:0] MODE_HOST = 2'b00;
endpackage

// File: rtl/xf_match.sv
module xf_match #(
    parameter int CW = 8,
    parameter logic [CW-1:0] XON_INIT  = 8'h11,
    parameter logic [CW-1:0] XOFF_INIT = 8'h13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chr_wr,
    input  logic          chr_sel,
    input  logic [CW-1:0] chr_data,
    input  logic          rx_valid,
    input  logic [CW-1:0] rx_data,
    input  logic          rx_full,
    output logic          rec_xon,
    output logic          rec_xoff,
    output logic [CW-1:0] xon_char,
    output logic [CW-1:0] xoff_char,
    output logic          irq,
    output logic [1:0]    status
);
    typedef struct packed {
        logic [CW-1:0] xon;
        logic [CW-1:0] xoff;
        logic          irq;
        logic [1:0]    status;
    } match_st_t;

    match_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        rec_xoff = rx_valid && !rx_full && (rx_data == st_q.xoff);
        rec_xon  = rx_valid && !rx_full && (rx_data == st_q.xon) && !rec_xoff;
        st_d.irq = rec_xon || rec_xoff;
        if (rec_xon || rec_xoff) st_d.status = {rec_xoff, rec_xon};
        if (chr_wr) begin
            if (chr_sel) st_d.xoff = chr_data;
            else         st_d.xon  = chr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{xon: XON_INIT, xoff: XOFF_INIT, irq: 1'b0, status: 2'b00};
        end else begin
            st_q <= st_d;
        end
    end

    assign xon_char  = st_q.xon;
    assign xoff_char = st_q.xoff;
    assign irq       = st_q.irq;
    assign status    = st_q.status;

    assert_irq_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_full && (rx_data == xoff_char)) |=> (irq && status == 2'b10));

    assert_overrun_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full || !rx_valid) |=> !irq);
endmodule

// File: rtl/xf_txgate.sv
module xf_txgate (
    input  logic clk,
    input  logic rst_n,
    input  logic auto_tx,
    input  logic cmd_stop,
    input  logic cmd_resume,
    input  logic rec_xon,
    input  logic rec_xoff,
    output logic tx_en
);
    typedef struct packed {
        logic stopped;
    } gate_st_t;

    gate_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (auto_tx) begin
            if (rec_xoff)     st_d.stopped = 1'b1;
            else if (rec_xon) st_d.stopped = 1'b0;
        end else begin
            if (cmd_stop)        st_d.stopped = 1'b1;
            else if (cmd_resume) st_d.stopped = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{stopped: 1'b0};
        else        st_q <= st_d;
    end

    assign tx_en = !st_q.stopped;

    assert_auto_ignores_host_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_tx && !rec_xon && !rec_xoff) |=> $stable(tx_en));

    assert_host_ignores_rx_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_tx && !cmd_stop && !cmd_resume) |=> $stable(tx_en));
endmodule

// File: rtl/xf_insert.sv
module xf_insert #(
    parameter int FW = 9,
    parameter int CW = 8,
    parameter int HI_MARK = 240,
    parameter int LO_MARK = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode,
    input  logic [FW-1:0] fill,
    input  logic          host_send,
    input  logic          host_kind,
    input  logic          kill,
    input  logic          ack,
    input  logic [CW-1:0] xon_char,
    input  logic [CW-1:0] xoff_char,
    output logic          req,
    output logic [CW-1:0] char_o,
    output logic          outstanding
);
    import xf_pkg::*;

    localparam logic [FW-1:0] HI = FW'(HI_MARK);
    localparam logic [FW-1:0] LO = FW'(LO_MARK);

    typedef struct packed {
        logic sent;
        logic auto_p;
        logic host_p;
        logic hkind;
    } ins_st_t;

    ins_st_t st_d, st_q;
    logic    ack_eff;
    logic    is_xoff;

    always_comb begin
        st_d    = st_q;
        ack_eff = ack && (st_q.auto_p || st_q.host_p);
        if (ack_eff) begin
            if (st_q.auto_p) begin
                st_d.sent = !st_q.sent;
            end else begin
                st_d.sent   = st_q.hkind;
                st_d.host_p = 1'b0;
            end
        end
        if (host_send) begin
            st_d.host_p = 1'b1;
            st_d.hkind  = host_kind;
        end else if (kill && mode == MODE_HOST) begin
            st_d.host_p = 1'b0;
        end
        if (mode == MODE_HOST) st_d.sent = 1'b0;
        st_d.auto_p = mode[1] && (st_d.sent ? (fill < LO) : (fill > HI));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req         = st_q.auto_p || st_q.host_p;
    assign is_xoff     = st_q.auto_p ? !st_q.sent : st_q.hkind;
    assign char_o      = is_xoff ? xoff_char : xon_char;
    assign outstanding = st_q.sent;

    assert_xoff_recorded_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && req && is_xoff && mode != MODE_HOST && !host_send) |=> outstanding);

    assert_host_mode_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HOST) |=> !outstanding);

    assert_auto_needs_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode[1]) |=> !(req && !st_q.host_p));
endmodule

// File: rtl/xonxoff_flow_ctrl.sv
module xonxoff_flow_ctrl #(
    parameter int FW = 9,
    parameter int CW = 8,
    parameter int HI_MARK = 240,
    parameter int LO_MARK = 16,
    parameter logic [CW-1:0] XON_INIT  = 8'h11,
    parameter logic [CW-1:0] XOFF_INIT = 8'h13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode,
    input  logic          strip,
    input  logic          chr_wr,
    input  logic          chr_sel,
    input  logic [CW-1:0] chr_data,
    input  logic          rx_valid,
    input  logic [CW-1:0] rx_data,
    input  logic          rx_full,
    input  logic [FW-1:0] rx_fill,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_code,
    input  logic          ins_ack,
    output logic          tx_en,
    output logic          ins_req,
    output logic [CW-1:0] ins_char,
    output logic          rx_wr_suppress,
    output logic          recog_irq,
    output logic [1:0]    recog_status,
    output logic          xoff_outstanding
);
    import xf_pkg::*;

    logic          rec_xon, rec_xoff;
    logic [CW-1:0] xon_char, xoff_char;
    logic          c_stop, c_resume, c_send, c_kind, c_kill;

    always_comb begin
        c_stop   = cmd_valid && (cmd_code == CMD_STOP);
        c_resume = cmd_valid && (cmd_code == CMD_RESUME);
        c_send   = cmd_valid && ((cmd_code == CMD_SEND_XON) || (cmd_code == CMD_SEND_XOFF));
        c_kind   = (cmd_code == CMD_SEND_XOFF);
        c_kill   = cmd_valid && (cmd_code == CMD_KILL);
    end

    xf_match #(.CW(CW), .XON_INIT(XON_INIT), .XOFF_INIT(XOFF_INIT)) u_match (
        .clk(clk), .rst_n(rst_n),
        .chr_wr(chr_wr), .chr_sel(chr_sel), .chr_data(chr_data),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_full(rx_full),
        .rec_xon(rec_xon), .rec_xoff(rec_xoff),
        .xon_char(xon_char), .xoff_char(xoff_char),
        .irq(recog_irq), .status(recog_status)
    );

    xf_txgate u_gate (
        .clk(clk), .rst_n(rst_n), .auto_tx(mode[0]),
        .cmd_stop(c_stop), .cmd_resume(c_resume),
        .rec_xon(rec_xon), .rec_xoff(rec_xoff), .tx_en(tx_en)
    );

    xf_insert #(.FW(FW), .CW(CW), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK)) u_ins (
        .clk(clk), .rst_n(rst_n), .mode(mode), .fill(rx_fill),
        .host_send(c_send), .host_kind(c_kind), .kill(c_kill), .ack(ins_ack),
        .xon_char(xon_char), .xoff_char(xoff_char),
        .req(ins_req), .char_o(ins_char), .outstanding(xoff_outstanding)
    );

    assign rx_wr_suppress = strip && (rec_xon || rec_xoff);

    assert_overrun_no_strip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |-> !rx_wr_suppress);

    assert_overrun_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_full && mode[0]) |=> $stable(tx_en));
endmodule

// File: tb/xonxoff_flow_ctrl_test.sv
module xonxoff_flow_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       strip = 1'b0, chr_wr = 1'b0, chr_sel = 1'b0;
    logic [7:0] chr_data = 8'h00, rx_data = 8'h00;
    logic       rx_valid = 1'b0, rx_full = 1'b0, cmd_valid = 1'b0, ins_ack = 1'b0;
    logic [8:0] rx_fill = 9'd100;
    logic [2:0] cmd_code = 3'd0;
    logic       tx_en, ins_req, rx_wr_suppress, recog_irq, xoff_outstanding;
    logic [7:0] ins_char;
    logic [1:0] recog_status;

    int checks = 0, errors = 0;
    bit done = 0;

    // bench model state
    logic [7:0] m_xon, m_xoff;
    logic       m_irq, m_stopped, m_sent, m_auto, m_host, m_hkind;
    logic [1:0] m_status;

    always #10 clk = ~clk;

    xonxoff_flow_ctrl uut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .strip(strip),
        .chr_wr(chr_wr), .chr_sel(chr_sel), .chr_data(chr_data),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_full(rx_full), .rx_fill(rx_fill),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .ins_ack(ins_ack),
        .tx_en(tx_en), .ins_req(ins_req), .ins_char(ins_char),
        .rx_wr_suppress(rx_wr_suppress), .recog_irq(recog_irq),
        .recog_status(recog_status), .xoff_outstanding(xoff_outstanding)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic f_rec_xoff();
        return rx_valid && !rx_full && rx_data == m_xoff;
    endfunction

    function automatic logic f_rec_xon();
        return rx_valid && !rx_full && rx_data == m_xon && !f_rec_xoff();
    endfunction

    function automatic logic f_req();
        return m_auto || m_host;
    endfunction

    function automatic logic [7:0] f_char();
        logic k;
        k = m_auto ? !m_sent : m_hkind;
        return k ? m_xoff : m_xon;
    endfunction

    task automatic model_reset();
        m_xon = 8'h11; m_xoff = 8'h13; m_irq = 0; m_status = 0; m_stopped = 0;
        m_sent = 0; m_auto = 0; m_host = 0; m_hkind = 0;
    endtask

    task automatic model_update();
        logic rxo, rxn, ackf, snd;
        rxo = f_rec_xoff(); rxn = f_rec_xon();
        ackf = ins_ack && f_req();
        snd = cmd_valid && (cmd_code == 3'd3 || cmd_code == 3'd4);
        m_irq = rxo || rxn;
        if (rxo || rxn) m_status = {rxo, rxn};
        if (mode[0]) begin
            if (rxo) m_stopped = 1; else if (rxn) m_stopped = 0;
        end else if (cmd_valid) begin
            if (cmd_code == 3'd1) m_stopped = 1; else if (cmd_code == 3'd2) m_stopped = 0;
        end
        if (ackf) begin
            if (m_auto) m_sent = !m_sent;
            else begin m_sent = m_hkind; m_host = 0; end
        end
        if (snd) begin m_host = 1; m_hkind = (cmd_code == 3'd4); end
        else if (cmd_valid && cmd_code == 3'd5 && mode == 2'b00) m_host = 0;
        if (mode == 2'b00) m_sent = 0;
        m_auto = mode[1] && (m_sent ? (rx_fill < 9'd16) : (rx_fill > 9'd240));
        if (chr_wr) begin
            if (chr_sel) m_xoff = chr_data; else m_xon = chr_data;
        end
    endtask

    task automatic compare_regs();
        chk(recog_irq == m_irq, "R2 irq", recog_irq, m_irq);
        chk(recog_status == m_status, "R2 status", recog_status, m_status);
        if (mode[0]) chk(tx_en == !m_stopped, "R5 tx_en", tx_en, !m_stopped);
        else         chk(tx_en == !m_stopped, "R6 tx_en", tx_en, !m_stopped);
        chk(ins_req == f_req(), "R7 ins_req", ins_req, f_req());
        if (f_req()) chk(ins_char == f_char(), "R7 ins_char", ins_char, f_char());
        chk(xoff_outstanding == m_sent, "R9 outstanding", xoff_outstanding, m_sent);
    endtask

    // inputs are already set (away from the edge); check comb, clock, check regs
    task automatic step();
        #1;
        chk(rx_wr_suppress == (strip && (f_rec_xon() || f_rec_xoff())), "R4 suppress",
            rx_wr_suppress, strip && (f_rec_xon() || f_rec_xoff()));
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare_regs();
        rx_valid = 0; cmd_valid = 0; ins_ack = 0; chr_wr = 0;
    endtask

    task automatic rx(input logic [7:0] d);
        rx_valid = 1; rx_data = d; step();
    endtask

    task automatic cmd(input logic [2:0] c);
        cmd_valid = 1; cmd_code = c; step();
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20251));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(tx_en == 1 && ins_req == 0 && recog_irq == 0 && xoff_outstanding == 0 && recog_status == 0,
            "R1 reset", {tx_en, ins_req, recog_irq, xoff_outstanding}, 4'b1000);
        cmd(3'd3);
        chk(ins_char == 8'h11, "R1 default resume", ins_char, 8'h11);
        cmd(3'd4);
        chk(ins_char == 8'h13, "R1 default pause", ins_char, 8'h13);
        ins_ack = 1; step();

        // R2 / R4 host mode recognition
        mode = 2'b00; strip = 0;
        rx(8'h11);
        chk(recog_irq == 1 && recog_status == 2'b01, "R2 resume seen", recog_status, 2'b01);
        step();
        chk(recog_irq == 0, "R2 one-cycle pulse", recog_irq, 0);
        strip = 1; rx_valid = 1; rx_data = 8'h13; #1;
        chk(rx_wr_suppress == 1, "R4 strip on", rx_wr_suppress, 1);
        step();
        chk(tx_en == 1, "R6 rx pause ignored in host", tx_en, 1);

        // R6 host stop / resume
        cmd(3'd1);
        chk(tx_en == 0, "R6 stop", tx_en, 0);
        rx(8'h11);
        chk(tx_en == 0, "R6 rx resume ignored", tx_en, 0);
        cmd(3'd2);
        chk(tx_en == 1, "R6 resume cmd", tx_en, 1);

        // R5 auto transmit gating
        mode = 2'b01;
        rx(8'h13);
        chk(tx_en == 0, "R5 pause stops", tx_en, 0);
        cmd(3'd2);
        chk(tx_en == 0, "R5 host resume ignored", tx_en, 0);
        rx(8'h11);
        chk(tx_en == 1, "R5 resume restarts", tx_en, 1);

        // R3 overrun
        rx_full = 1; rx_valid = 1; rx_data = 8'h13; #1;
        chk(rx_wr_suppress == 0, "R3 no suppress", rx_wr_suppress, 0);
        step();
        chk(tx_en == 1 && recog_irq == 0, "R3 ignored", {tx_en, recog_irq}, 2'b10);
        rx_full = 0;

        // R7 / R9 fill-driven insertion
        mode = 2'b10; rx_fill = 9'd241; step();
        chk(ins_req == 1 && ins_char == 8'h13, "R7 pause request", ins_char, 8'h13);
        ins_ack = 1; rx_fill = 9'd200; step();   // ack with fill dropping in same cycle
        chk(xoff_outstanding == 1 && ins_req == 0, "R9 pause sent once", {xoff_outstanding, ins_req}, 2'b10);
        rx_fill = 9'd250; step();
        chk(ins_req == 0, "R9 no repeat", ins_req, 0);
        rx_fill = 9'd15; step();
        chk(ins_req == 1 && ins_char == 8'h11, "R7 resume request", ins_char, 8'h11);
        ins_ack = 1; step();
        chk(xoff_outstanding == 0, "R9 resume clears", xoff_outstanding, 1'b0);

        // R8 rescind
        rx_fill = 9'd245; step();
        rx_fill = 9'd200; step();
        chk(ins_req == 0 && xoff_outstanding == 0, "R8 rescinded", ins_req, 0);

        // R10 host mode clears outstanding
        rx_fill = 9'd245; step();
        ins_ack = 1; step();
        mode = 2'b00; rx_fill = 9'd5; step();
        chk(xoff_outstanding == 0 && ins_req == 0, "R10 cleared", {xoff_outstanding, ins_req}, 0);

        // R11 host send and kill
        cmd(3'd3);
        chk(ins_req == 1 && ins_char == 8'h11, "R11 host send", ins_char, 8'h11);
        cmd(3'd5);
        chk(ins_req == 0, "R11 kill in host mode", ins_req, 0);
        mode = 2'b10; rx_fill = 9'd100; cmd(3'd4);
        cmd(3'd5);
        chk(ins_req == 1, "R11 kill ignored in auto", ins_req, 1);
        ins_ack = 1; step();

        // R2 reprogrammed character
        mode = 2'b01; chr_wr = 1; chr_sel = 0; chr_data = 8'h41; step();
        rx(8'h41);
        chk(recog_irq == 1 && recog_status == 2'b01, "R2 new resume char", recog_status, 2'b01);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            int r;
            if ($urandom % 50 == 0) mode = 2'($urandom);
            strip = ($urandom % 4 == 0) ? ~strip : strip;
            r = $urandom % 4;
            if (r == 0) rx_fill = 9'($urandom % 20);
            else if (r == 1) rx_fill = 9'(230 + $urandom % 30);
            else if (r == 2) rx_fill = 9'($urandom % 257);
            rx_valid = ($urandom % 3 == 0);
            r = $urandom % 4;
            rx_data = (r == 0) ? m_xon : (r == 1) ? m_xoff : 8'($urandom);
            rx_full = ($urandom % 8 == 0);
            cmd_valid = ($urandom % 6 == 0);
            cmd_code = 3'($urandom % 7);
            ins_ack = ($urandom % 3 == 0);
            chr_wr = ($urandom % 100 == 0);
            chr_sel = 1'($urandom);
            chr_data = ($urandom % 2 == 0) ? (chr_sel ? 8'h13 : 8'h11) : 8'($urandom);
            step();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule